// File: doc/BRIEF.md
# Relative Branch and Call Target Unit

This unit produces the next program counter for the control-transfer instructions of a processor with 20-bit nibble addresses. The decoder hands it the address of the instruction, a class code, the offset nibbles as fetched from the instruction stream, and the already-evaluated condition result. One cycle later the unit returns the next program counter, whether control left the sequential path, and what it did to its built-in return-address stack.

Each class measures its displacement from its own base point. A conditional branch adds a sign-extended 8-bit displacement to the address where that displacement sits. Relative jumps and calls use 12-bit or 16-bit displacements, and a call also saves the address of the following instruction. A conditional branch with an all-zero displacement does not jump: when its condition holds, it returns by popping the stack. The stack also serves explicit push and pop instructions and the plain return instructions, two of which also ask for the carry flag to be set or cleared.

Top module: `bpu_branch_unit`

## Requirements
- R1: After synchronous reset `npc_vld_o`, `npc_o`, `taken_o`, `push_o`, `push_val_o`, `pop_val_o`, `ovf_o`, `udf_o`, `carry_set_o` and `carry_clr_o` are all zero, and the return stack is empty.
- R2: Every cycle with `valid_i` high is answered by `npc_vld_o` high on the following cycle. `npc_vld_o` is low after any cycle with `valid_i` low.
- R3: Offset nibble k sits at `off_i[4k+3:4k]`, and nibble 0 is the least significant and the first fetched. The sign of a relative displacement is the top bit of its top nibble.
- R4: Conditional branch classes are op 0 (base 1), op 1 (base 3) and op 2 (base 5). With `cond_i` high and `off_i[7:0]` non-zero, `npc_o` = pc + base + sign-extended `off_i[7:0]` and `taken_o` is 1.
- R5: A conditional branch with `cond_i` low gives `npc_o` = pc + base + 2 with `taken_o` 0, and the stack is left alone.
- R6: A conditional branch with `cond_i` high and `off_i[7:0]` zero pops the stack. `npc_o` and `pop_val_o` then both equal the popped value.
- R7: Op 3 (3-nibble jump) targets pc + 1 + sext(`off_i[11:0]`). Op 4 (4-nibble jump) targets pc + 2 + sext(`off_i[15:0]`). Neither touches the stack.
- R8: Op 5 (3-nibble call) targets pc + 4 + sext(`off_i[11:0]`) and pushes pc + 4. Op 6 (4-nibble call) targets pc + 6 + sext(`off_i[15:0]`) and pushes pc + 6. In both cases `push_o` = 1 and `push_val_o` = the pushed value.
- R9: Op 7 (absolute jump) sets `npc_o` = `off_i`. Op 8 (absolute call) does the same and also pushes pc + 7.
- R10: Ops 9, 10 and 11 pop the stack into `npc_o` whatever `cond_i` is. Op 10 raises `carry_set_o` and op 11 raises `carry_clr_o` for that cycle.
- R11: Op 12 pushes `data_i`. Op 13 pops into `pop_val_o`. Both give `npc_o` = pc + 2 with `taken_o` 0.
- R12: The stack holds `STK_DEPTH` entries in last-in first-out order. A push onto a full stack drops the oldest entry and pulses `ovf_o`.
- R13: A pop from an empty stack yields zero and pulses `udf_o`, and the stack stays empty.
- R14: All address sums wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 4 | Instruction class code |
| pc_i | input | 20 | Address of the instruction |
| off_i | input | 20 | Offset or absolute-address nibbles, least significant first |
| cond_i | input | 1 | Evaluated branch condition |
| data_i | input | 20 | Value for an explicit push |
| npc_vld_o | output | 1 | Result valid |
| npc_o | output | 20 | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| push_o | output | 1 | A value was pushed |
| push_val_o | output | 20 | The pushed value |
| pop_val_o | output | 20 | The popped value (zero when nothing popped) |
| ovf_o | output | 1 | Push discarded the oldest entry |
| udf_o | output | 1 | Pop found the stack empty |
| carry_set_o | output | 1 | Return variant requests carry set |
| carry_clr_o | output | 1 | Return variant requests carry clear |

## Verification
The bench builds the unit with the full 20-bit address width and shrinks `STK_DEPTH` to 4. At that depth a handful of calls or pushes fills the stack, so discarding the oldest entry and popping an empty stack are both exercised many times within short instruction sequences. The bench sweeps all 256 short displacements for each conditional class, with the condition both true and false, using addresses near the top of the space so that the sums wrap. It also strides through the 12-bit and 16-bit jump and call displacements, and it tracks the stack contents in its own queue model.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [3:0] {
    OP_BR_CARRY = 4'd0,
    OP_BR_CMP   = 4'd1,
    OP_BR_BIT   = 4'd2,
    OP_JMP3     = 4'd3,
    OP_JMP4     = 4'd4,
    OP_CALL3    = 4'd5,
    OP_CALL4    = 4'd6,
    OP_JMP_ABS  = 4'd7,
    OP_CALL_ABS = 4'd8,
    OP_RET      = 4'd9,
    OP_RET_SETC = 4'd10,
    OP_RET_CLRC = 4'd11,
    OP_PUSH     = 4'd12,
    OP_POP      = 4'd13,
    OP_RSV14    = 4'd14,
    OP_RSV15    = 4'd15
  } bpu_op_e;

  localparam int NIB_W = 4;

  // distance from the instruction address to its displacement field
  localparam int BASE_CARRY = 1;
  localparam int BASE_CMP   = 3;
  localparam int BASE_BIT   = 5;
  localparam int BASE_JMP3  = 1;
  localparam int BASE_JMP4  = 2;

  // instruction lengths in nibbles (used for fall-through and link)
  localparam int LEN_CALL3    = 4;
  localparam int LEN_CALL4    = 6;
  localparam int LEN_CALL_ABS = 7;
  localparam int LEN_STACKOP  = 2;

  // short displacement is two nibbles, followed by nothing
  localparam int SHORT_NIBS = 2;

  function automatic logic is_cond_branch(bpu_op_e op);
    return (op == OP_BR_CARRY) || (op == OP_BR_CMP) || (op == OP_BR_BIT);
  endfunction

  function automatic logic is_call(bpu_op_e op);
    return (op == OP_CALL3) || (op == OP_CALL4) || (op == OP_CALL_ABS);
  endfunction

  function automatic logic is_return(bpu_op_e op);
    return (op == OP_RET) || (op == OP_RET_SETC) || (op == OP_RET_CLRC);
  endfunction

endpackage

// File: rtl/bpu_offset_sext.sv
module bpu_offset_sext #(
  parameter int NIBS = 2,
  parameter int AW   = 20
) (
  input  logic [NIBS*bpu_pkg::NIB_W-1:0] raw_i,
  output logic [AW-1:0]                  val_o
);
  localparam int RW = NIBS * bpu_pkg::NIB_W;
  localparam int XW = AW - RW;

  generate
    if (XW > 0) begin : g_ext
      assign val_o = {{XW{raw_i[RW-1]}}, raw_i};
    end else begin : g_trunc
      assign val_o = raw_i[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/bpu_target.sv
module bpu_target
  import bpu_pkg::*;
#(
  parameter int AW = 20
) (
  input  bpu_op_e       op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] off_i,
  output logic [AW-1:0] tgt_o,
  output logic [AW-1:0] fall_o,
  output logic [AW-1:0] link_o,
  output logic          zero_off_o
);
  localparam int NW     = 3;            // short, 3-nibble, 4-nibble
  localparam int SHORTW = SHORT_NIBS * NIB_W;

  logic [AW-1:0] sx [NW];

  genvar gi;
  generate
    for (gi = 0; gi < NW; gi++) begin : g_sext
      localparam int NN = (gi == 0) ? SHORT_NIBS : gi + 2;
      bpu_offset_sext #(.NIBS(NN), .AW(AW)) u_sx (
        .raw_i (off_i[NN*NIB_W-1:0]),
        .val_o (sx[gi])
      );
    end
  endgenerate

  logic [AW-1:0] base;
  logic [AW-1:0] disp;
  logic          absolute;

  always_comb begin
    base     = '0;
    disp     = '0;
    absolute = 1'b0;
    fall_o   = pc_i;
    link_o   = '0;
    unique case (op_i)
      OP_BR_CARRY: begin
        base = AW'(BASE_CARRY); disp = sx[0];
        fall_o = pc_i + AW'(BASE_CARRY + SHORT_NIBS);
      end
      OP_BR_CMP: begin
        base = AW'(BASE_CMP); disp = sx[0];
        fall_o = pc_i + AW'(BASE_CMP + SHORT_NIBS);
      end
      OP_BR_BIT: begin
        base = AW'(BASE_BIT); disp = sx[0];
        fall_o = pc_i + AW'(BASE_BIT + SHORT_NIBS);
      end
      OP_JMP3: begin base = AW'(BASE_JMP3); disp = sx[1]; end
      OP_JMP4: begin base = AW'(BASE_JMP4); disp = sx[2]; end
      OP_CALL3: begin
        base = AW'(LEN_CALL3); disp = sx[1];
        link_o = pc_i + AW'(LEN_CALL3);
      end
      OP_CALL4: begin
        base = AW'(LEN_CALL4); disp = sx[2];
        link_o = pc_i + AW'(LEN_CALL4);
      end
      OP_JMP_ABS: absolute = 1'b1;
      OP_CALL_ABS: begin
        absolute = 1'b1;
        link_o = pc_i + AW'(LEN_CALL_ABS);
      end
      OP_PUSH, OP_POP: fall_o = pc_i + AW'(LEN_STACKOP);
      default: ;
    endcase
  end

  assign tgt_o      = absolute ? off_i : (pc_i + base + disp);
  assign zero_off_o = (off_i[SHORTW-1:0] == '0);
endmodule

// File: rtl/bpu_ret_stack.sv
module bpu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [AW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] DEPTH_C = DEPTH[PW:0];

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] top_idx;
  logic [PW:0]   count;

  // storage: write-only port, no reset, so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push_i) begin
      wr_ptr <= wr_ptr + 1'b1;           // at full this overwrites the oldest
      if (count != DEPTH_C) count <= count + 1'b1;
    end else if (pop_i && (count != '0)) begin
      wr_ptr <= wr_ptr - 1'b1;
      count  <= count - 1'b1;
    end
  end

  assign top_idx = wr_ptr - 1'b1;
  assign empty_o = (count == '0);
  assign full_o  = (count == DEPTH_C);
  assign top_o   = empty_o ? '0 : mem[top_idx];

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R12
  AST_STK_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    push_i && full_o |=> full_o); // R12
  AST_STK_GROW: assert property (@(posedge clk) disable iff (rst)
    push_i && !full_o |=> count == $past(count) + 1'b1); // R12
  AST_STK_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    pop_i && !push_i && empty_o |=> empty_o); // R13
  AST_STK_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    !(push_i && pop_i)); // R12
endmodule

// File: rtl/bpu_branch_unit.sv
module bpu_branch_unit
  import bpu_pkg::*;
#(
  parameter int AW        = 20,
  parameter int STK_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] off_i,
  input  logic          cond_i,
  input  logic [AW-1:0] data_i,
  output logic          npc_vld_o,
  output logic [AW-1:0] npc_o,
  output logic          taken_o,
  output logic          push_o,
  output logic [AW-1:0] push_val_o,
  output logic [AW-1:0] pop_val_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          carry_set_o,
  output logic          carry_clr_o
);
  bpu_op_e       op;
  logic [AW-1:0] tgt, fall, link, stk_top;
  logic          zero_off, stk_full, stk_empty;
  logic          do_push, do_pop, take;
  logic [AW-1:0] push_data, npc_n, pop_val_n;

  assign op = bpu_op_e'(op_i);

  bpu_target #(.AW(AW)) u_target (
    .op_i       (op),
    .pc_i       (pc_i),
    .off_i      (off_i),
    .tgt_o      (tgt),
    .fall_o     (fall),
    .link_o     (link),
    .zero_off_o (zero_off)
  );

  bpu_ret_stack #(.DEPTH(STK_DEPTH), .AW(AW)) u_stack (
    .clk         (clk),
    .rst         (rst),
    .push_i      (do_push),
    .push_data_i (push_data),
    .pop_i       (do_pop),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  always_comb begin
    do_push   = 1'b0;
    do_pop    = 1'b0;
    take      = 1'b0;
    npc_n     = pc_i;
    push_data = link;
    if (is_cond_branch(op)) begin
      if (cond_i) begin
        take   = 1'b1;
        do_pop = zero_off;
        npc_n  = zero_off ? stk_top : tgt;
      end else begin
        npc_n  = fall;
      end
    end else if (is_call(op)) begin
      take    = 1'b1;
      do_push = 1'b1;
      npc_n   = tgt;
    end else if (is_return(op)) begin
      take   = 1'b1;
      do_pop = 1'b1;
      npc_n  = stk_top;
    end else begin
      unique case (op)
        OP_JMP3, OP_JMP4, OP_JMP_ABS: begin take = 1'b1; npc_n = tgt; end
        OP_PUSH: begin do_push = 1'b1; push_data = data_i; npc_n = fall; end
        OP_POP:  begin do_pop  = 1'b1; npc_n = fall; end
        default: ;
      endcase
    end
    do_push   = do_push & valid_i;
    do_pop    = do_pop & valid_i;
    pop_val_n = do_pop ? stk_top : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_vld_o   <= 1'b0;
      npc_o       <= '0;
      taken_o     <= 1'b0;
      push_o      <= 1'b0;
      push_val_o  <= '0;
      pop_val_o   <= '0;
      ovf_o       <= 1'b0;
      udf_o       <= 1'b0;
      carry_set_o <= 1'b0;
      carry_clr_o <= 1'b0;
    end else begin
      npc_vld_o   <= valid_i;
      taken_o     <= valid_i & take;
      push_o      <= do_push;
      ovf_o       <= do_push & stk_full;
      udf_o       <= do_pop & stk_empty;
      carry_set_o <= valid_i & (op == OP_RET_SETC);
      carry_clr_o <= valid_i & (op == OP_RET_CLRC);
      if (valid_i) begin
        npc_o      <= npc_n;
        push_val_o <= do_push ? push_data : '0;
        pop_val_o  <= pop_val_n;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> npc_vld_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !npc_vld_o && !push_o && !udf_o); // R2
  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_cond_branch(op) && !cond_i |=> !taken_o && !udf_o && !push_o); // R5
  AST_JUMP_NO_STACK: assert property (@(posedge clk) disable iff (rst)
    valid_i && (op == OP_JMP3 || op == OP_JMP4 || op == OP_JMP_ABS)
      |=> taken_o && !push_o && !udf_o); // R7
  AST_CALL_PUSHES: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_call(op) |=> push_o && taken_o); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_o && udf_o)); // R13
  AST_CARRY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(carry_set_o && carry_clr_o)); // R10
endmodule

// File: tb/tb_bpu_branch_unit.sv
`timescale 1ns/1ps
module tb_bpu_branch_unit;
  localparam int AW = 20;
  localparam int TB_DEPTH = 4;

  logic clk = 1'b0;
  logic rst;
  logic valid_i;
  logic [3:0] op_i;
  logic [AW-1:0] pc_i, off_i, data_i;
  logic cond_i;
  logic npc_vld_o, taken_o, push_o, ovf_o, udf_o, carry_set_o, carry_clr_o;
  logic [AW-1:0] npc_o, push_val_o, pop_val_o;

  always #4 clk = ~clk;   // 125 MHz

  bpu_branch_unit #(.AW(AW), .STK_DEPTH(TB_DEPTH)) dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .pc_i(pc_i),
    .off_i(off_i), .cond_i(cond_i), .data_i(data_i),
    .npc_vld_o(npc_vld_o), .npc_o(npc_o), .taken_o(taken_o), .push_o(push_o),
    .push_val_o(push_val_o), .pop_val_o(pop_val_o), .ovf_o(ovf_o),
    .udf_o(udf_o), .carry_set_o(carry_set_o), .carry_clr_o(carry_clr_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [AW-1:0] mq[$];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sx8(input logic [7:0] v);
    return {{(AW-8){v[7]}}, v};
  endfunction
  function automatic logic [AW-1:0] sx12(input logic [11:0] v);
    return {{(AW-12){v[11]}}, v};
  endfunction
  function automatic logic [AW-1:0] sx16(input logic [15:0] v);
    return {{(AW-16){v[15]}}, v};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [AW-1:0] pc,
                       input logic [AW-1:0] off, input logic cond,
                       input logic [AW-1:0] data);
    logic [AW-1:0] e_npc = pc, e_pv = '0, e_qv = '0, base = '0;
    logic e_tk = 0, e_push = 0, e_ovf = 0, e_udf = 0, e_pop = 0;
    string tag;
    case (op)
      0, 1, 2: begin
        base = (op == 0) ? 20'd1 : (op == 1) ? 20'd3 : 20'd5;
        if (!cond) begin tag = "R5"; e_npc = pc + base + 20'd2; end
        else if (off[7:0] == 8'h00) begin tag = "R6"; e_tk = 1; e_pop = 1; end
        else begin tag = "R4"; e_tk = 1; e_npc = pc + base + sx8(off[7:0]); end
      end
      3: begin tag = "R7"; e_tk = 1; e_npc = pc + 20'd1 + sx12(off[11:0]); end
      4: begin tag = "R7"; e_tk = 1; e_npc = pc + 20'd2 + sx16(off[15:0]); end
      5: begin tag = "R8"; e_tk = 1; e_push = 1; e_pv = pc + 20'd4;
               e_npc = pc + 20'd4 + sx12(off[11:0]); end
      6: begin tag = "R8"; e_tk = 1; e_push = 1; e_pv = pc + 20'd6;
               e_npc = pc + 20'd6 + sx16(off[15:0]); end
      7: begin tag = "R9"; e_tk = 1; e_npc = off; end
      8: begin tag = "R9"; e_tk = 1; e_npc = off; e_push = 1; e_pv = pc + 20'd7; end
      9, 10, 11: begin tag = "R10"; e_tk = 1; e_pop = 1; end
      12: begin tag = "R11"; e_push = 1; e_pv = data; e_npc = pc + 20'd2; end
      13: begin tag = "R11"; e_pop = 1; e_npc = pc + 20'd2; end
      default: tag = "R2";
    endcase
    if (e_pop) begin
      if (mq.size() == 0) begin e_udf = 1; e_qv = '0; end
      else e_qv = mq.pop_back();
      if (op != 13) e_npc = e_qv;
    end
    if (e_push) begin
      mq.push_back(e_pv);
      if (mq.size() > TB_DEPTH) begin void'(mq.pop_front()); e_ovf = 1; end
    end
    valid_i = 1'b1; op_i = op; pc_i = pc; off_i = off; cond_i = cond; data_i = data;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R2", "npc_vld_o", 32'(npc_vld_o), 32'd1);
    chk(tag, "npc_o", 32'(npc_o), 32'(e_npc));
    chk(tag, "taken_o", 32'(taken_o), 32'(e_tk));
    chk(tag, "push_o", 32'(push_o), 32'(e_push));
    chk(tag, "push_val_o", 32'(push_val_o), 32'(e_pv));
    chk(tag, "pop_val_o", 32'(pop_val_o), 32'(e_qv));
    chk("R12", "ovf_o", 32'(ovf_o), 32'(e_ovf));
    chk("R13", "udf_o", 32'(udf_o), 32'(e_udf));
    chk("R10", "carry_set_o", 32'(carry_set_o), 32'(op == 10));
    chk("R10", "carry_clr_o", 32'(carry_clr_o), 32'(op == 11));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid_i = 0; op_i = 0; pc_i = 0; off_i = 0; cond_i = 0; data_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "npc_vld_o", 32'(npc_vld_o), 0);
    chk("R1", "npc_o", 32'(npc_o), 0);
    chk("R1", "taken_o", 32'(taken_o), 0);
    chk("R1", "push_o|ovf|udf", 32'({push_o, ovf_o, udf_o}), 0);
    chk("R1", "push/pop values", 32'(push_val_o | pop_val_o), 0);
    chk("R1", "carry flags", 32'({carry_set_o, carry_clr_o}), 0);

    // R13 pop on empty, R11 explicit push/pop, R12 overflow drops oldest
    issue(13, 20'h01000, 0, 0, 0);
    for (int i = 0; i < TB_DEPTH + 2; i++) issue(12, 20'h02000 + 20'(i), 0, 0, 20'hA0000 + 20'(i * 17));
    for (int i = 0; i < TB_DEPTH + 2; i++) issue(13, 20'h03000, 0, 1, 0);
    // R2 idle cycle
    @(negedge clk);
    chk("R2", "npc_vld_o idle", 32'(npc_vld_o), 0);

    // R4/R5/R6/R14 exhaustive short displacement sweep near the top of space
    for (int c = 0; c < 3; c++)
      for (int o = 0; o < 256; o++)
        for (int k = 0; k < 2; k++) begin
          if (o % 64 == 0) issue(5, 20'hFFF00 + 20'(o), 20'h00123, 0, 0);
          issue(4'(c), 20'hFFF80 + 20'(o), 20'(o) | 20'hFFF00, k[0], 0);
        end

    // R6 explicit: call then zero-offset branch returns to call's next instruction
    issue(5, 20'h40000, 20'h00010, 0, 0);
    issue(1, 20'h50000, 20'h00000, 1, 0);
    chk("R6", "return to link", 32'(npc_o), 32'h40004);

    // R7/R8 strided sweeps over wider displacements
    for (int o = 0; o < 4096; o += 37) begin
      issue(3, 20'hFF800 + 20'(o), 20'(o), 0, 0);
      issue(5, 20'h00400 + 20'(o), 20'(o), 0, 0);
      if (o % 3 == 0) issue(9, 20'h0, 0, 0, 0);
    end
    for (int o = 0; o < 65536; o += 997) begin
      issue(4, 20'hF0000 + 20'(o), 20'(o), 0, 0);
      issue(6, 20'h0A000 + 20'(o), 20'(o), 0, 0);
      if (o % 2 == 0) issue(10, 20'h0, 0, 1, 0);
      else issue(11, 20'h0, 0, 0, 0);
    end

    // R9 absolute transfers
    issue(7, 20'h12345, 20'hABCDE, 0, 0);
    issue(8, 20'hFFFFC, 20'h54321, 0, 0);
    issue(9, 20'h00000, 0, 0, 0);
    chk("R9", "absolute call link wraps", 32'(npc_o), 32'h00003);

    // R3 nibble order
    issue(4, 20'h00100, 20'h00021, 0, 0);
    chk("R3", "low nibble first", 32'(npc_o), 32'h00123);
    issue(3, 20'h00100, 20'h00800, 0, 0);
    chk("R3", "sign from top nibble", 32'(npc_o), 32'hFF901);
    // R14 wrap
    issue(3, 20'hFFFFE, 20'h00005, 0, 0);
    chk("R14", "wrap", 32'(npc_o), 32'h00004);

    // R10 returns drain the stack then underflow
    for (int i = 0; i < TB_DEPTH + 1; i++) issue(4'(9 + i % 3), 20'h0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule